// File: doc/BRIEF.md
# Trigger Route Slice with Edge-to-Pulse Shaping

This block takes a wide bundle of trigger sources and routes one of them to a single trigger line. An index input names the source. The chosen signal can pass through as a level. It can also be reduced to one-clock pulses that mark its rising edges, its falling edges, or both. The result can be inverted, and an output enable can force the line low.

The output is registered. It reflects the inputs one clock edge after they are applied. A chip normally places many slices next to each other, all fed from the same source vector, and gives each slice its own static configuration.

Top module: `trig_route_slice`

## Requirements
- R1: The 6-bit index `src_sel` picks bit `src_sel` of `src_vec`, covering 0 through 63. No other bit of `src_vec` affects `trig_o`.
- R2: When both `rise_pulse_en` and `fall_pulse_en` are low, the selected level appears on `trig_o` one clock edge after it is applied.
- R3: When `rise_pulse_en` is high, a 0-to-1 change of the selected source makes `trig_o` high for exactly one clock cycle, starting at the first edge that samples the new value.
- R4: When `fall_pulse_en` is high, a 1-to-0 change of the selected source makes `trig_o` high for exactly one clock cycle, starting at the first edge that samples the new value.
- R5: When both pulse enables are high, either kind of change produces a one-cycle pulse. A source that holds steady produces no pulse.
- R6: When `invert_en` is high, the output of the level or pulse stage is inverted. In pulse mode the idle line is high and each pulse is a one-cycle low.
- R7: When `out_en` is low, `trig_o` is low at the next edge, regardless of `invert_en`.
- R8: In a pulse mode, a change of `src_sel` never produces a pulse in the cycle of the change, even if the old and new sources differ in level.
- R9: `trig_o` is low while the asynchronous active-low reset `rst_n` is asserted. In a pulse mode, no pulse is produced on the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_vec | input | 64 | Trigger source bundle |
| src_sel | input | 6 | Index of the routed source |
| rise_pulse_en | input | 1 | Emit a pulse on each rising edge of the selected source |
| fall_pulse_en | input | 1 | Emit a pulse on each falling edge of the selected source |
| invert_en | input | 1 | Invert after the level/pulse stage |
| out_en | input | 1 | Gate for the output line |
| trig_o | output | 1 | Registered trigger output |

## Verification
The properties assume that the source bundle is already synchronous to `clk`, so any change is seen at exactly one edge. They also assume that the configuration inputs hold across the cycles a property spans. The pulse-width property, for example, only applies when the mode was the same on the previous edge.

The directed stimulus meets these assumptions. It changes every input only one time unit after a rising edge. It holds the mode steady around each edge it checks, and it changes the index only in the cycles whose behaviour is under test.

// File: rtl/trs_pkg.sv
package trs_pkg;

    // Static shaping configuration of one slice
    typedef struct packed {
        logic rise;   // pulse on 0->1
        logic fall;   // pulse on 1->0
        logic inv;    // invert after shaping
        logic en;     // output gate
    } trs_mode_t;

    // Registered output state of the slice
    typedef struct packed {
        logic trig;
    } trs_out_st_t;

endpackage

// File: rtl/trs_select.sv
module trs_select #(
    parameter int N_IN  = 64,
    parameter int SEL_W = 6
) (
    input  logic [N_IN-1:0]  src_vec,
    input  logic [SEL_W-1:0] src_sel,
    output logic             bit_o
);
    // One-hot decode ANDed with the sources, then OR-reduced
    logic [N_IN-1:0] hit;

    for (genvar g = 0; g < N_IN; g++) begin : g_hit
        assign hit[g] = (src_sel == SEL_W'(g)) & src_vec[g];
    end

    assign bit_o = |hit;
endmodule

// File: rtl/trs_edge.sv
module trs_edge #(
    parameter int SEL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             rise_o,
    output logic             fall_o
);
    typedef struct packed {
        logic             hist;  // selected level one cycle earlier
        logic             vld;   // history holds a post-reset sample
        logic [SEL_W-1:0] sel;   // index the history belongs to
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     same_src;

    always_comb begin
        st_d      = st_q;
        st_d.hist = bit_i;
        st_d.sel  = sel_i;
        st_d.vld  = 1'b1;
        // history only comparable when taken from the same source
        same_src  = st_q.vld && (sel_i == st_q.sel);
        rise_o    = same_src &&  bit_i && !st_q.hist;
        fall_o    = same_src && !bit_i &&  st_q.hist;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/trs_shape.sv
module trs_shape
    import trs_pkg::*;
(
    input  trs_mode_t mode_i,
    input  logic      level_i,
    input  logic      rise_i,
    input  logic      fall_i,
    output logic      out_o
);
    logic staged;

    always_comb begin
        if (mode_i.rise || mode_i.fall) begin
            staged = (mode_i.rise && rise_i) || (mode_i.fall && fall_i);
        end else begin
            staged = level_i;
        end
        out_o = mode_i.en && (staged ^ mode_i.inv);
    end
endmodule

// File: rtl/trig_route_slice.sv
module trig_route_slice
    import trs_pkg::*;
#(
    parameter int N_IN = 64,
    localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  src_vec,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             rise_pulse_en,
    input  logic             fall_pulse_en,
    input  logic             invert_en,
    input  logic             out_en,
    output logic             trig_o
);
    trs_mode_t   mode;
    trs_out_st_t st_d, st_q;
    logic        sel_bit, rise_ev, fall_ev, shaped;

    assign mode.rise = rise_pulse_en;
    assign mode.fall = fall_pulse_en;
    assign mode.inv  = invert_en;
    assign mode.en   = out_en;

    trs_select #(.N_IN(N_IN), .SEL_W(SEL_W)) sel_i (
        .src_vec (src_vec),
        .src_sel (src_sel),
        .bit_o   (sel_bit)
    );

    trs_edge #(.SEL_W(SEL_W)) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_i  (sel_bit),
        .sel_i  (src_sel),
        .rise_o (rise_ev),
        .fall_o (fall_ev)
    );

    trs_shape shape_i (
        .mode_i  (mode),
        .level_i (sel_bit),
        .rise_i  (rise_ev),
        .fall_i  (fall_ev),
        .out_o   (shaped)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trig = shaped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_o = st_q.trig;
endmodule

// File: rtl/trs_checker.sv
module trs_checker #(
    parameter int N_IN = 64,
    localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IN-1:0]  src_vec,
    input logic [SEL_W-1:0] src_sel,
    input logic             rise_pulse_en,
    input logic             fall_pulse_en,
    input logic             invert_en,
    input logic             out_en,
    input logic             trig_o
);
    assert_level_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_pulse_en && !fall_pulse_en && out_en && !invert_en)
        |=> (trig_o == $past(src_vec[src_sel])));

    assert_level_invert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_pulse_en && !fall_pulse_en && out_en && invert_en)
        |=> (trig_o == !$past(src_vec[src_sel])));

    assert_rise_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rise_pulse_en && out_en && !invert_en
         && (src_sel == $past(src_sel))
         && src_vec[src_sel] && !$past(src_vec[src_sel]))
        |=> trig_o);

    assert_fall_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && fall_pulse_en && out_en && !invert_en
         && (src_sel == $past(src_sel))
         && !src_vec[src_sel] && $past(src_vec[src_sel]))
        |=> trig_o);

    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && rise_pulse_en && !fall_pulse_en && out_en && !invert_en
         && $past(rise_pulse_en && !fall_pulse_en && out_en && !invert_en))
        |=> !trig_o);

    assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> !trig_o);

    assert_sel_switch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (src_sel != $past(src_sel))
         && (rise_pulse_en || fall_pulse_en) && !invert_en)
        |=> !trig_o);

    always_comb begin
        if (!rst_n) begin
            assert_reset_low_R9: assert (!trig_o);
        end
    end
endmodule

bind trig_route_slice trs_checker #(.N_IN(N_IN)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_vec       (src_vec),
    .src_sel       (src_sel),
    .rise_pulse_en (rise_pulse_en),
    .fall_pulse_en (fall_pulse_en),
    .invert_en     (invert_en),
    .out_en        (out_en),
    .trig_o        (trig_o)
);

// File: tb/trig_route_slice_tb.sv
module trig_route_slice_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_vec = '0;
    logic [5:0]  src_sel = '0;
    logic        rise_pulse_en = 1'b0;
    logic        fall_pulse_en = 1'b0;
    logic        invert_en = 1'b0;
    logic        out_en = 1'b0;
    logic        trig_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trig_route_slice dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_vec       (src_vec),
        .src_sel       (src_sel),
        .rise_pulse_en (rise_pulse_en),
        .fall_pulse_en (fall_pulse_en),
        .invert_en     (invert_en),
        .out_en        (out_en),
        .trig_o        (trig_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string rq, input logic exp);
        n_tests++;
        if (trig_o !== exp) begin
            n_fail++;
            $display("FAIL %s: trig_o=%b expected %b", rq, trig_o, exp);
        end
    endtask

    task automatic set_mode(input logic r, input logic f, input logic inv, input logic en);
        rise_pulse_en = r;
        fall_pulse_en = f;
        invert_en     = inv;
        out_en        = en;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        src_vec = '1;
        src_sel = 6'd9;
        set_mode(0, 0, 1, 1);
        step();
        chk("R9 held in reset", 1'b0);
        set_mode(1, 0, 0, 1);
        rst_n = 1'b1;
        step();
        chk("R9 no pulse after release", 1'b0);
        step();
        chk("R9 steady high source", 1'b0);
    endtask

    task automatic t_level();
        set_mode(0, 0, 0, 1);
        src_sel = 6'd5;
        src_vec = '0;
        step();
        chk("R2 level low", 1'b0);
        src_vec = 64'd1 << 5;
        step();
        chk("R2 level high", 1'b1);
        src_vec = ~(64'd1 << 5);
        step();
        chk("R1 other bits ignored", 1'b0);
        src_sel = 6'd63;
        src_vec = 64'd1 << 63;
        step();
        chk("R1 index 63 high", 1'b1);
        src_vec = ~(64'd1 << 63);
        step();
        chk("R1 index 63 low", 1'b0);
        src_sel = 6'd0;
        src_vec = 64'd1;
        step();
        chk("R1 index 0 high", 1'b1);
    endtask

    task automatic t_invert_level();
        set_mode(0, 0, 1, 1);
        src_sel = 6'd0;
        src_vec = 64'd1;
        step();
        chk("R6 inverted high", 1'b0);
        src_vec = '0;
        step();
        chk("R6 inverted low", 1'b1);
    endtask

    task automatic t_rise();
        set_mode(1, 0, 0, 1);
        src_sel = 6'd12;
        src_vec = '0;
        step();
        step();
        chk("R3 idle", 1'b0);
        src_vec = 64'd1 << 12;
        step();
        chk("R3 pulse", 1'b1);
        step();
        chk("R3 pulse ends", 1'b0);
        step();
        chk("R3 steady high", 1'b0);
        src_vec = '0;
        step();
        chk("R3 falling ignored", 1'b0);
    endtask

    task automatic t_fall();
        set_mode(0, 1, 0, 1);
        src_sel = 6'd40;
        src_vec = 64'd1 << 40;
        step();
        step();
        chk("R4 idle high source", 1'b0);
        src_vec = '0;
        step();
        chk("R4 pulse", 1'b1);
        step();
        chk("R4 pulse ends", 1'b0);
        src_vec = 64'd1 << 40;
        step();
        chk("R4 rising ignored", 1'b0);
    endtask

    task automatic t_both();
        set_mode(1, 1, 0, 1);
        src_sel = 6'd33;
        src_vec = '0;
        step();
        step();
        chk("R5 idle", 1'b0);
        src_vec = 64'd1 << 33;
        step();
        chk("R5 rise pulse", 1'b1);
        step();
        chk("R5 rise pulse ends", 1'b0);
        src_vec = '0;
        step();
        chk("R5 fall pulse", 1'b1);
        step();
        chk("R5 fall pulse ends", 1'b0);
    endtask

    task automatic t_invert_pulse();
        set_mode(1, 0, 1, 1);
        src_sel = 6'd2;
        src_vec = '0;
        step();
        step();
        chk("R6 inverted idle high", 1'b1);
        src_vec = 64'd1 << 2;
        step();
        chk("R6 inverted pulse low", 1'b0);
        step();
        chk("R6 inverted pulse ends", 1'b1);
    endtask

    task automatic t_gate();
        set_mode(0, 0, 1, 0);
        src_sel = 6'd2;
        src_vec = '0;
        step();
        chk("R7 disabled despite invert", 1'b0);
        set_mode(1, 0, 0, 0);
        src_vec = 64'd1 << 2;
        step();
        chk("R7 disabled edge", 1'b0);
        out_en = 1'b1;
        step();
        chk("R7 enable without edge", 1'b0);
    endtask

    task automatic t_sel_switch();
        set_mode(1, 0, 0, 1);
        src_vec = 64'd1 << 7;
        src_sel = 6'd3;
        step();
        step();
        chk("R8 idle on low source", 1'b0);
        src_sel = 6'd7;
        step();
        chk("R8 no pulse low-to-high switch", 1'b0);
        step();
        chk("R8 still quiet", 1'b0);
        set_mode(0, 1, 0, 1);
        step();
        src_sel = 6'd3;
        step();
        chk("R8 no pulse high-to-low switch", 1'b0);
        set_mode(1, 0, 0, 1);
        src_vec = (64'd1 << 7) | (64'd1 << 3);
        step();
        chk("R8 new source edge detected", 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_level();
        t_invert_level();
        t_rise();
        t_fall();
        t_both();
        t_invert_pulse();
        t_gate();
        t_sel_switch();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule